// File: doc/BRIEF.md
# Packed Program Counter and Status Register

This block keeps one 32-bit word that combines a word-aligned 26-bit program counter with the processor status: four condition flags, two interrupt mask bits and a two-bit mode field. A core uses it as the register that instruction fetch advances, that branches and returns write, and that the ALU updates flags in. Reading it always yields the whole packed word.

A write to the register carries a 32-bit value and a status-update flag. The fields that the write may change depend on that flag and on the current privilege. Without the flag, only the address field moves. With the flag, a privileged mode may rewrite every field, and so can drop into user mode. User mode may change only the address and the condition flags, so it cannot raise its own privilege. A sequential advance steps the address by one word. A separate flag port loads the condition flags alone.

Top module: `pcsr_unit`

## Requirements
- R1: After reset, rd_data reads 0x0C000003: address 0, flags 0, both interrupt masks set, supervisor mode. Layout: flags in bits 31:28, interrupt masks in bits 27:26, address in bits 25:2, mode in bits 1:0. Mode 0 is user mode and any nonzero mode is privileged. 3 is supervisor mode.
- R2: In a privileged mode, a write with wr_status=1 replaces all 32 bits with wr_data.
- R3: In user mode, a write with wr_status=1 takes bits 31:28 and 25:2 from wr_data and keeps bits 27:26 and 1:0, so a request to enter supervisor mode has no effect.
- R4: A write with wr_status=0 takes bits 25:2 from wr_data and keeps bits 31:26 and 1:0, in every mode.
- R5: An advance with no write adds 4 to the address, wraps from 0x03FFFFFC to 0, and keeps all status bits.
- R6: A flag update with no write loads bits 31:28 from flag_data and changes no other bit.
- R7: When a write and a flag update occur in the same cycle, the write alone takes effect and flag_data is discarded.
- R8: When a write and an advance occur in the same cycle, the address comes from wr_data and is not advanced.
- R9: When an advance and a flag update occur without a write, both take effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write the register this cycle |
| wr_data | input | 32 | Value to write, packed layout |
| wr_status | input | 1 | Write may update status fields |
| adv_en | input | 1 | Advance the address by one word |
| flag_en | input | 1 | Load condition flags from flag_data |
| flag_data | input | 4 | New condition flags |
| rd_data | output | 32 | Packed register contents |

## Verification
Three functions can fall in the same cycle, and the flag port against a register write is the pair that needs a rule. The bench sweeps every mode, both values of the status flag, and each combination of the write, advance and flag strobes, over several data patterns. For each case it computes the expected word from the requirement priorities and compares rd_data one cycle later. The case of a write together with a flag update passes only if the written flags appear, or the old ones when the written bits are masked out, and flag_data never does.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;
  localparam int FLAG_W = 4;
  localparam int IRQ_W  = 2;
  localparam int PC_W   = 24;
  localparam int MODE_W = 2;
  localparam int WORD_W = FLAG_W + IRQ_W + PC_W + MODE_W;
  localparam int PC_LO  = MODE_W;
  localparam int PC_HI  = PC_LO + PC_W - 1;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic [IRQ_W-1:0]  irq;
    logic [PC_W-1:0]   pc;
    logic [MODE_W-1:0] mode;
  } pcsr_t;

  localparam logic [MODE_W-1:0] MODE_USER = '0;
  localparam logic [MODE_W-1:0] MODE_SVC  = '1;

  localparam pcsr_t PCSR_RESET = '{flags: '0, irq: '1, pc: '0, mode: MODE_SVC};
endpackage

// File: rtl/pcsr_rst_sync.sv
module pcsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) shift_q <= '0;
    else           shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = shift_q[STAGES-1];
endmodule

// File: rtl/pcsr_write_merge.sv
module pcsr_write_merge import pcsr_pkg::*; (
  input  pcsr_t              cur,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               wstatus,
  output pcsr_t              merged
);
  pcsr_t src;
  logic  privileged;

  assign src        = pcsr_t'(wdata);
  assign privileged = (cur.mode != MODE_USER);

  always_comb begin
    merged    = cur;
    merged.pc = src.pc;
    if (wstatus) begin
      merged.flags = src.flags;
      if (privileged) begin
        merged.irq  = src.irq;
        merged.mode = src.mode;
      end
    end
  end
endmodule

// File: rtl/pcsr_pc_step.sv
module pcsr_pc_step #(
  parameter int W = 24
) (
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] pc_out
);
  assign pc_out = pc_in + W'(1);
endmodule

// File: rtl/pcsr_unit.sv
module pcsr_unit import pcsr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_status,
  input  logic              adv_en,
  input  logic              flag_en,
  input  logic [FLAG_W-1:0] flag_data,
  output logic [WORD_W-1:0] rd_data
);
  logic            rst_sn;
  pcsr_t           cur_q;
  pcsr_t           nxt;
  pcsr_t           merged;
  logic [PC_W-1:0] pc_inc;
  logic            reg_en;

  pcsr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sn)
  );

  pcsr_write_merge u_merge (
    .cur     (cur_q),
    .wdata   (wr_data),
    .wstatus (wr_status),
    .merged  (merged)
  );

  pcsr_pc_step #(.W(PC_W)) u_step (
    .pc_in  (cur_q.pc),
    .pc_out (pc_inc)
  );

  assign reg_en = wr_en | adv_en | flag_en;

  // Write wins over both advance and flag port; those two combine.
  always_comb begin
    nxt = cur_q;
    if (wr_en) begin
      nxt = merged;
    end else begin
      if (adv_en)  nxt.pc    = pc_inc;
      if (flag_en) nxt.flags = flag_data;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     cur_q <= PCSR_RESET;
    else if (reg_en) cur_q <= nxt;
  end

  assign rd_data = cur_q;

  // R3: user mode cannot alter interrupt masks or mode
  a_r3_user_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && wr_status && cur_q.mode == MODE_USER) |=> ($stable(cur_q.irq) && $stable(cur_q.mode)));

  // R4: plain write keeps every status field
  a_r4_plain_keeps_status: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && !wr_status) |=> ($stable(cur_q.flags) && $stable(cur_q.irq) && $stable(cur_q.mode)));

  // R5: advance steps one word
  a_r5_advance_step: assert property (@(posedge clk) disable iff (!rst_sn)
    (adv_en && !wr_en) |=> (cur_q.pc == $past(cur_q.pc) + PC_W'(1)));

  // R6: flag port leaves the address alone
  a_r6_flag_keeps_pc: assert property (@(posedge clk) disable iff (!rst_sn)
    (flag_en && !wr_en && !adv_en) |=> $stable(cur_q.pc));

  // R7: flag port is discarded under a write
  a_r7_write_blocks_flags: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && !wr_status && flag_en) |=> $stable(cur_q.flags));

  // R8: write address beats advance
  a_r8_write_beats_adv: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && adv_en) |=> (cur_q.pc == $past(wr_data[PC_HI:PC_LO])));
endmodule

// File: tb/test_pcsr_unit.sv
module test_pcsr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_status, adv_en, flag_en;
  logic [31:0] wr_data;
  logic [3:0]  flag_data;
  logic [31:0] rd_data;
  int          nchk = 0;
  int          nfail = 0;
  logic [31:0] expv;

  always #2.5 clk = ~clk;

  pcsr_unit i_pcsr_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_status(wr_status), .adv_en(adv_en), .flag_en(flag_en),
    .flag_data(flag_data), .rd_data(rd_data)
  );

  function automatic logic [31:0] model(input logic [31:0] c, input logic wr,
      input logic [31:0] d, input logic st, input logic adv, input logic fe,
      input logic [3:0] fd);
    logic [31:0] n;
    n = c;
    if (wr) begin
      n[25:2] = d[25:2];
      if (st) begin
        n[31:28] = d[31:28];
        if (c[1:0] != 2'd0) begin
          n[27:26] = d[27:26];
          n[1:0]   = d[1:0];
        end
      end
    end else begin
      if (adv) n[25:2] = c[25:2] + 24'd1;
      if (fe)  n[31:28] = fd;
    end
    return n;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_status = 0; adv_en = 0; flag_en = 0; wr_data = '0; flag_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    expv = 32'h0C000003;
  endtask

  // drive at negedge, register at posedge, sample at next negedge
  task automatic op(input logic wr, input logic [31:0] d, input logic st,
      input logic adv, input logic fe, input logic [3:0] fd);
    wr_en = wr; wr_data = d; wr_status = st; adv_en = adv; flag_en = fe; flag_data = fd;
    expv = model(expv, wr, d, st, adv, fe, fd);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(5ns * 150000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle();
    do_reset();
    check("R1 reset value", rd_data, 32'h0C000003);

    // Sweep: every mode, status flag and strobe combination, four data patterns
    for (int m = 0; m < 4; m++)
      for (int st = 0; st < 2; st++)
        for (int wr = 0; wr < 2; wr++)
          for (int adv = 0; adv < 2; adv++)
            for (int fe = 0; fe < 2; fe++)
              for (int p = 0; p < 4; p++) begin
                logic [31:0] d, setup;
                logic [3:0]  fd;
                string tag;
                d  = (32'h9E3779B9 * (p + 1)) ^ (32'h0F0F0F0F << p);
                fd = 4'(4'hA ^ p[3:0] ^ {2'b0, m[1:0]});
                setup = {4'h5, 2'b10, 24'(32'h00ABCD + p), m[1:0]};
                do_reset();
                op(1, setup, 1, 0, 0, 4'h0);
                check("R2 privileged setup", rd_data, setup);
                if (wr && fe)            tag = "R7 write vs flag port";
                else if (wr && adv)      tag = "R8 write vs advance";
                else if (adv && fe)      tag = "R9 advance with flags";
                else if (wr && st && m == 0) tag = "R3 user flagged write";
                else if (wr && st)       tag = "R2 privileged flagged write";
                else if (wr)             tag = "R4 plain write";
                else if (adv)            tag = "R5 advance";
                else if (fe)             tag = "R6 flag update";
                else                     tag = "R1 hold when idle";
                op(wr[0], d, st[0], adv[0], fe[0], fd);
                check(tag, rd_data, expv);
              end

    // R5: wrap of the address at the top of the space
    do_reset();
    op(1, 32'h03FFFFFC, 0, 0, 0, 4'h0);
    check("R4 plain write to top", rd_data, 32'h0FFFFFFF);
    op(0, 32'h0, 0, 1, 0, 4'h0);
    check("R5 advance wraps", rd_data, 32'h0C000003);

    // R2 then R3: drop to user, then try to regain supervisor mode
    do_reset();
    op(1, 32'hF4000000 | 32'h00000100, 1, 0, 0, 4'h0);
    check("R2 drop to user status", rd_data & ~32'h03FFFFFC, 32'hF4000000);
    op(1, 32'h3800000B | 32'h00000200, 1, 0, 0, 4'h0);
    check("R3 supervisor request ignored", rd_data & ~32'h03FFFFFC, 32'h34000000);
    check("R3 address taken", rd_data & 32'h03FFFFFC, 32'h00000208);
    op(1, 32'hC0000300, 0, 0, 0, 4'h0);
    check("R4 user plain write", rd_data, 32'h34000300);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule